// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block watches the time and date produced by an external real-time-clock counter and raises a sticky alarm flag when the programmed alarm fields agree with it. Six alarm bytes cover seconds, minutes, hours, day of month, month and day of week. Bit 7 of each byte is a participation enable, and bits 6:0 hold the BCD value. Year and sub-second time have no alarm byte, so they never affect the result.

The counter presents its BCD time bytes and pulses a one-cycle update strobe once per second. The match is evaluated only on that strobe. The flag sets only on the strobe where the match first appears, so a match that lasts for several updates yields one event. Software reaches the alarm bytes and a status/control byte through a simple register port. The flag clears when a 0 is written to it. It also clears on a status read when the auto-clear control bit is set.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, all six alarm bytes read 0x00 (every field disabled), the alarm flag is 0, and the auto-clear bit is 0.
- R2: The alarm bytes sit at addresses 0x0C (seconds), 0x0D (minutes), 0x0E (hours), 0x0F (day of month), 0x10 (month) and 0x11 (day of week). All 8 bits of each byte are writable, and they read back through `rd_data` in the same cycle as the address.
- R3: On an update strobe where at least one field is enabled and every enabled field matches its time input, the flag is 1 from the next clock edge. Disabled fields are not compared.
- R4: Only bits 6:0 take part in the comparison. Bit 7 of a time input and bit 7 of the alarm byte are never compared as values.
- R5: When all six enable bits are 0, the flag never sets.
- R6: The flag sets only on an update strobe where the match is present and the previous strobe had no match. A match that persists across strobes does not set the flag again after a clear.
- R7: A write to the status byte at 0x0B with bit 0 = 0 clears the flag. Writing bit 0 = 1 does not set the flag.
- R8: The status byte at 0x0B reads as {auto_clear, 6'b0, flag}. Bit 7 (auto_clear) is writable. When auto_clear is 1, a read strobe to 0x0B clears the flag after that edge. When auto_clear is 0, the read leaves the flag unchanged.
- R9: If a set event and a clearing write or clearing read fall on the same edge, the flag ends at 1.
- R10: Without an update strobe the flag never sets, even when the time inputs match.
- R11: Addresses outside 0x0B to 0x11 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe marking a new time value |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD |
| tm_date | input | 8 | Current day of month, BCD |
| tm_month | input | 8 | Current month, BCD |
| tm_dow | input | 8 | Current day of week, BCD |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (affects the auto-clear only) |
| reg_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_addr` (combinational) |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
The main sweep visits all 63 non-empty enable masks. For each mask it applies one strobe with a single enabled field off by one, which must not set the flag. It then applies a strobe where every enabled field agrees and every disabled field differs, which must set it. Together these show that the address-to-field mapping, the per-field masking and the all-fields AND are each correct. The time inputs in the matching strobe carry bit 7 set, which separates a 7-bit compare from an 8-bit one. Further patterns separate the following:
- a persistent match from a fresh one;
- no strobe from a strobe;
- a write of 1 from a write of 0 to the flag;
- a read with auto-clear set from one without;
- a set coinciding with a clear from a set alone.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 6;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5
  } field_e;

  // enable sits in bit 7 of an alarm byte
  function automatic logic field_enabled(input logic [BYTE_W-1:0] alarm_b);
    return alarm_b[BYTE_W-1];
  endfunction

  // a disabled field always agrees; an enabled one compares the 7 value bits
  function automatic logic field_agrees(input logic [BYTE_W-1:0] alarm_b,
                                        input logic [BYTE_W-1:0] time_b);
    return !alarm_b[BYTE_W-1] || (alarm_b[BYTE_W-2:0] == time_b[BYTE_W-2:0]);
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic auto_clr,
                                                    input logic flag);
    return {auto_clr, {(BYTE_W-2){1'b0}}, flag};
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int                ADDR_W     = 5,
  parameter logic [ADDR_W-1:0] ALARM_BASE = 5'h0C
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [BYTE_W-1:0]                     wdata,
  output logic [NUM_FIELDS-1:0][BYTE_W-1:0]     alarm_q
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(ALARM_BASE) + g);
    logic sel;
    assign sel = wr_en && (addr == MY_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   alarm_q[g] <= '0;
      else if (sel) alarm_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm_q,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] time_q,
  output logic                              match_now,
  output logic                              any_enable
);
  logic [NUM_FIELDS-1:0] agree;
  logic [NUM_FIELDS-1:0] en;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign agree[g] = field_agrees(alarm_q[g], time_q[g]);
    assign en[g]    = field_enabled(alarm_q[g]);
  end

  assign any_enable = |en;
  assign match_now  = any_enable && (&agree);
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match_now,
  input  logic clr_req,
  input  logic auto_wr,
  input  logic auto_wdata,
  output logic alarm_flag,
  output logic auto_clr,
  output logic match_event
);
  logic prev_match;

  assign match_event = tick && match_now && !prev_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_match <= 1'b0;
    else if (tick) prev_match <= match_now;
  end

  // set wins over any clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           alarm_flag <= 1'b0;
    else if (match_event) alarm_flag <= 1'b1;
    else if (clr_req)     alarm_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       auto_clr <= 1'b0;
    else if (auto_wr) auto_clr <= auto_wdata;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int                ADDR_W      = 5,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h0B,
  parameter logic [ADDR_W-1:0] ALARM_BASE  = 5'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [7:0]        tm_sec,
  input  logic [7:0]        tm_min,
  input  logic [7:0]        tm_hour,
  input  logic [7:0]        tm_date,
  input  logic [7:0]        tm_month,
  input  logic [7:0]        tm_dow,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        rd_data,
  output logic              alarm_flag
);
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm_q;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] time_q;
  logic match_now, any_enable, match_event, clr_req, auto_clr;
  logic stat_sel, stat_wr, stat_rd;

  // explicit field placement, independent of any time-register order
  always_comb begin
    time_q            = '0;
    time_q[FLD_SEC]   = tm_sec;
    time_q[FLD_MIN]   = tm_min;
    time_q[FLD_HOUR]  = tm_hour;
    time_q[FLD_DATE]  = tm_date;
    time_q[FLD_MONTH] = tm_month;
    time_q[FLD_DOW]   = tm_dow;
  end

  assign stat_sel = (reg_addr == STATUS_ADDR);
  assign stat_wr  = reg_wr && stat_sel;
  assign stat_rd  = reg_rd && stat_sel;
  assign clr_req  = (stat_wr && !reg_wdata[0]) || (stat_rd && auto_clr);

  rtc_alarm_regs #(.ADDR_W(ADDR_W), .ALARM_BASE(ALARM_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .alarm_q(alarm_q)
  );

  rtc_alarm_cmp u_cmp (
    .alarm_q(alarm_q), .time_q(time_q),
    .match_now(match_now), .any_enable(any_enable)
  );

  rtc_alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .match_now(match_now),
    .clr_req(clr_req), .auto_wr(stat_wr), .auto_wdata(reg_wdata[7]),
    .alarm_flag(alarm_flag), .auto_clr(auto_clr), .match_event(match_event)
  );

  always_comb begin
    rd_data = '0;
    if (stat_sel) rd_data = status_byte(auto_clr, alarm_flag);
    for (int i = 0; i < NUM_FIELDS; i++)
      if (reg_addr == ADDR_W'(int'(ALARM_BASE) + i)) rd_data = alarm_q[i];
  end
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
  input logic clk,
  input logic rst_n,
  input logic sec_tick,
  input logic alarm_flag,
  input logic match_event,
  input logic match_now,
  input logic any_enable,
  input logic clr_req
);
  assert_set_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(sec_tick));

  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_event |=> alarm_flag);

  assert_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_enable |-> !match_now);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !match_event) |=> !alarm_flag);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_event && !clr_req) |=> $stable(alarm_flag));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .alarm_flag(alarm_flag),
  .match_event(match_event), .match_now(match_now),
  .any_enable(any_enable), .clr_req(clr_req)
);

// File: tb/rtc_alarm_match_test.sv
module rtc_alarm_match_test;
  logic clk = 0, rst_n = 0, sec_tick = 0;
  logic [7:0] tm [6];
  logic [4:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd_data;
  logic alarm_flag;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // alarm values per field: sec, min, hour, date, month, dow
  localparam logic [7:0] AV [6] = '{8'h45, 8'h30, 8'h12, 8'h25, 8'h11, 8'h03};

  always #4 clk = ~clk;

  rtc_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .tm_sec(tm[0]), .tm_min(tm[1]), .tm_hour(tm[2]), .tm_date(tm[3]),
    .tm_month(tm[4]), .tm_dow(tm[5]), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .alarm_flag(alarm_flag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = rd_data;
  endtask

  task automatic rd_strobe(input logic [4:0] a);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic set_time(input logic [7:0] v [6]);
    for (int i = 0; i < 6; i++) tm[i] = v[i];
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic program_mask(input logic [5:0] m);
    for (int i = 0; i < 6; i++) wr(5'h0C + 5'(i), AV[i] | {m[i], 7'b0});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] t [6];
    for (int i = 0; i < 6; i++) tm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin rd(5'h0C + 5'(i), d); check("R1 alarm byte", d, 8'h00); end
    rd(5'h0B, d); check("R1 status", d, 8'h00);
    check("R1 flag", {7'b0, alarm_flag}, 8'h00);

    // R2 write/readback, all bits
    for (int i = 0; i < 6; i++) wr(5'h0C + 5'(i), 8'hA0 ^ 8'(i * 17));
    for (int i = 0; i < 6; i++) begin rd(5'h0C + 5'(i), d); check("R2 readback", d, 8'hA0 ^ 8'(i * 17)); end

    // R11 unmapped address
    wr(5'h05, 8'hFF); wr(5'h12, 8'hFF);
    rd(5'h05, d); check("R11 unmapped read", d, 8'h00);
    rd(5'h12, d); check("R11 unmapped read", d, 8'h00);
    for (int i = 0; i < 6; i++) begin rd(5'h0C + 5'(i), d); check("R11 untouched", d, 8'hA0 ^ 8'(i * 17)); end

    // R5 no enables, everything equal
    program_mask(6'h00);
    for (int i = 0; i < 6; i++) t[i] = AV[i];
    set_time(t); tick(); tick();
    check("R5 no enable", {7'b0, alarm_flag}, 8'h00);

    // R3/R4/R2 sweep all masks
    for (int m = 1; m < 64; m++) begin
      int low;
      program_mask(6'(m));
      wr(5'h0B, 8'h00);
      low = 0;
      for (int i = 5; i >= 0; i--) if (m[i]) low = i;
      for (int i = 0; i < 6; i++) t[i] = m[i] ? AV[i] : (AV[i] ^ 8'h02);
      t[low] = AV[low] ^ 8'h01;
      set_time(t); tick();
      check("R3 one enabled field off", {7'b0, alarm_flag}, 8'h00);
      for (int i = 0; i < 6; i++) t[i] = m[i] ? (AV[i] | 8'h80) : (AV[i] ^ 8'h04);
      set_time(t); tick();
      check("R3 R4 enabled fields agree", {7'b0, alarm_flag}, 8'h01);
    end

    // R6 persistent match
    program_mask(6'h3F);
    for (int i = 0; i < 6; i++) t[i] = AV[i];
    set_time(t); tick();
    wr(5'h0B, 8'h00);
    check("R7 clear by write", {7'b0, alarm_flag}, 8'h00);
    tick(); tick();
    check("R6 persistent no reset", {7'b0, alarm_flag}, 8'h00);
    t[0] = AV[0] ^ 8'h10; set_time(t); tick();
    t[0] = AV[0]; set_time(t); tick();
    check("R6 fresh match", {7'b0, alarm_flag}, 8'h01);

    // R10 no tick
    wr(5'h0B, 8'h00);
    t[0] = AV[0] ^ 8'h10; set_time(t); tick();
    t[0] = AV[0]; set_time(t);
    repeat (5) @(negedge clk);
    check("R10 no strobe", {7'b0, alarm_flag}, 8'h00);
    tick();
    check("R10 strobe", {7'b0, alarm_flag}, 8'h01);

    // R7 write 1 does not set
    wr(5'h0B, 8'h00);
    wr(5'h0B, 8'h01);
    check("R7 write one", {7'b0, alarm_flag}, 8'h00);

    // R8 auto-clear off: read leaves flag
    t[0] = AV[0] ^ 8'h10; set_time(t); tick();
    t[0] = AV[0]; set_time(t); tick();
    rd_strobe(5'h0B);
    check("R8 read no auto", {7'b0, alarm_flag}, 8'h01);
    rd(5'h0B, d); check("R8 status layout", d, 8'h01);
    // auto-clear on (write also clears flag)
    wr(5'h0B, 8'h80);
    t[0] = AV[0] ^ 8'h10; set_time(t); tick();
    t[0] = AV[0]; set_time(t); tick();
    rd(5'h0B, d); check("R8 status layout auto", d, 8'h81);
    rd_strobe(5'h0B);
    check("R8 auto clear read", {7'b0, alarm_flag}, 8'h00);

    // R9 set vs clearing read (auto on)
    t[0] = AV[0] ^ 8'h10; set_time(t); tick();
    t[0] = AV[0]; set_time(t);
    @(negedge clk); reg_addr = 5'h0B; reg_rd = 1; sec_tick = 1;
    @(negedge clk); reg_rd = 0; sec_tick = 0;
    check("R9 set beats read clear", {7'b0, alarm_flag}, 8'h01);
    // R9 set vs clearing write
    t[0] = AV[0] ^ 8'h10; set_time(t); tick();
    t[0] = AV[0]; set_time(t);
    @(negedge clk); reg_addr = 5'h0B; reg_wdata = 8'h80; reg_wr = 1; sec_tick = 1;
    @(negedge clk); reg_wr = 0; sec_tick = 0;
    check("R9 set beats write clear", {7'b0, alarm_flag}, 8'h01);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule